// File: doc/BRIEF.md
# Register-Range Macro Expander

This block sits in a CPU front end between instruction fetch and the execution pipeline. Every instruction is a 64-bit word fetched from a 64-bit-aligned address. The block takes one word at a time over a valid/ready handshake. An ordinary instruction goes out unchanged. A range-XOR macro is unrolled into a run of plain register-XOR instructions, one for each register in the named range. Each run is identical to code written out by hand.

Expanded instructions leave one per cycle over a second valid/ready interface. While a run is in progress the fetch side is held off. The unrolling rule is built from a counter and fixed logic, with no table or microcode store. A synchronous flush abandons whatever is in flight. Two one-cycle pulses report misaligned fetches and malformed macros. In both cases nothing is emitted.

Top module: `macro_expander`

## Requirements
- R1: After reset, out_valid, misalign_err and illegal_err are 0 and in_ready is 1.
- R2: An aligned word whose opcode (bits [63:56]) is not the range-XOR macro opcode 8'h2B is presented on out_insn unchanged. out_valid is high in the cycle right after the word is accepted.
- R3: A word accepted with any of in_addr[2:0] set is not emitted. misalign_err is high for exactly the one cycle after acceptance. Misalignment takes precedence over every other check, so illegal_err stays low.
- R4: A macro with opcode 8'h2B names a first register n in bits [55:48] and a last register m in bits [47:40]. It emits, in ascending order for i = n..m, the word {8'h2A, 2'b00,i, 2'b00,i, 2'b00,i, 32'h0}. That is the plain XOR opcode, with destination in [55:48], first source in [47:40] and second source in [39:32].
- R5: out_last is 1 on the final instruction of an expansion and on every pass-through word. It is 0 on every earlier instruction of an expansion.
- R6: A macro with n > m, or with either of bits [7:6] of its n or m field nonzero, emits nothing. illegal_err is high for the one cycle after acceptance.
- R7: in_ready is 0 whenever out_valid is 1. A new word is taken only from the cycle after the final instruction has been accepted downstream.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_insn stays unchanged. The range position does not advance.
- R9: When flush is 1, no input is accepted in that cycle, and out_valid is 0 in the next cycle. Any partly emitted run is discarded.
- R10: A macro with n equal to m emits exactly one instruction, with out_last set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Abort expansion and drop the pending input |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Block can take a fetch word |
| in_insn | input | 64 | Fetched instruction word |
| in_addr | input | ADDR_W (32) | Fetch address of the word |
| out_valid | output | 1 | Instruction available downstream |
| out_ready | input | 1 | Downstream takes the instruction |
| out_insn | output | 64 | Emitted instruction |
| out_last | output | 1 | Final instruction of an expansion, or a pass-through word |
| misalign_err | output | 1 | One-cycle pulse for a misaligned fetch |
| illegal_err | output | 1 | One-cycle pulse for a malformed macro |

## Verification
The assertions assume that reset is held for several cycles before any traffic, so every $past lies inside the post-reset window. They also assume that flush is a clean synchronous level that may arrive in any state. The stall and freeze properties are suspended in a flush cycle, because flush is allowed to override a stalled output. The stimulus keeps to these assumptions. It drives inputs on the falling edge only, releases reset well before the first word, and raises flush once, during a deliberately stalled expansion. Downstream readiness follows a fixed irregular pattern, so stalls fall on first, middle and final instructions of a run.

// File: rtl/mx_pkg.sv
// Package: shared constants and helpers for the macro expander.
// Assumes 64-bit instruction words with an 8-bit opcode in the top byte and
// 8-bit register fields below it.
package mx_pkg;

    localparam int INSN_W  = 64;
    localparam int OPC_W   = 8;
    localparam int FIELD_W = 8;

    typedef logic [INSN_W-1:0] insn_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [FIELD_W-1:0] field_t;

    // Bit positions of the fields an execution stage decodes.
    localparam int OPC_MSB  = 63;
    localparam int DST_MSB  = 55;
    localparam int SRC1_MSB = 47;
    localparam int SRC2_MSB = 39;

    // Builds a hand-equivalent register XOR: all three operands are the same register.
    function automatic insn_t make_self_xor(opc_t opc, field_t reg_f);
        insn_t w;
        w = '0;
        w[OPC_MSB  -: OPC_W]   = opc;
        w[DST_MSB  -: FIELD_W] = reg_f;
        w[SRC1_MSB -: FIELD_W] = reg_f;
        w[SRC2_MSB -: FIELD_W] = reg_f;
        return w;
    endfunction

endpackage

// File: rtl/mx_classify.sv
// Module: mx_classify
// Purely combinational decode of one fetched word. It reports whether the word
// is the range macro, whether its fetch address is misaligned, and whether the
// macro's register range is malformed. It also extracts the range bounds.
// Assumes: fields are FIELD_W wide and only the low REG_W bits name a register.
module mx_classify
    import mx_pkg::*;
#(
    parameter int   ADDR_W    = 32,
    parameter int   REG_W     = 6,
    parameter int   ALIGN_LSB = 3,
    parameter opc_t OPC_MACRO = 8'h2B
) (
    input  insn_t             insn,
    input  logic [ADDR_W-1:0] addr,
    output logic              is_macro,
    output logic              misaligned,
    output logic              bad_range,
    output logic [REG_W-1:0]  first_reg,
    output logic [REG_W-1:0]  last_reg
);

    localparam int PAD_W = FIELD_W - REG_W;

    field_t first_f;
    field_t last_f;
    logic   first_oob;
    logic   last_oob;

    // Pull out the opcode and the two range fields.
    always_comb begin
        is_macro = (insn[OPC_MSB -: OPC_W] == OPC_MACRO);
        first_f  = insn[DST_MSB  -: FIELD_W];
        last_f   = insn[SRC1_MSB -: FIELD_W];
    end

    // Range fields must leave their padding bits clear.
    always_comb begin
        first_oob = |first_f[FIELD_W-1 -: PAD_W];
        last_oob  = |last_f[FIELD_W-1 -: PAD_W];
        first_reg = first_f[REG_W-1:0];
        last_reg  = last_f[REG_W-1:0];
    end

    // Alignment check on the low address bits, and the overall range validity.
    always_comb begin
        misaligned = |addr[ALIGN_LSB-1:0];
        bad_range  = first_oob || last_oob || (first_reg > last_reg);
    end

endmodule

// File: rtl/mx_range_walker.sv
// Module: mx_range_walker
// Holds the current register index and the last index of an expansion. The
// index steps by one each time a micro-instruction is taken downstream.
// Assumes: the start bounds are already validated (first <= last).
module mx_range_walker #(
    parameter int REG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             start,
    input  logic [REG_W-1:0] first_reg,
    input  logic [REG_W-1:0] last_reg,
    input  logic             step,
    output logic             active,
    output logic [REG_W-1:0] idx,
    output logic             at_end
);

    logic [REG_W-1:0] lim;

    // Marks the final index of the range.
    always_comb begin
        at_end = (idx == lim);
    end

    // Tracks whether a run is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
        end else if (step && at_end) begin
            active <= 1'b0;
        end
    end

    // Loads the bounds at start and advances the index on each accepted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            lim <= '0;
        end else if (start) begin
            idx <= first_reg;
            lim <= last_reg;
        end else if (step && !at_end) begin
            idx <= idx + 1'b1;
        end
    end

    AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !at_end && !flush && !start) |=> (idx == REG_W'($past(idx) + 1'b1))); // R4
    AST_WALK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !step && !flush && !start) |=> $stable(idx)); // R8

endmodule

// File: rtl/macro_expander.sv
// Module: macro_expander (top)
// Accepts one fetched word per handshake into a single output slot. A plain
// word is held and emitted as is. A range macro loads the walker, which then
// supplies one self-XOR per cycle until the range ends. Misaligned words and
// malformed macros are dropped and reported with one-cycle pulses.
// Assumes: synchronous active-low reset held for a few cycles; flush is synchronous.
module macro_expander
    import mx_pkg::*;
#(
    parameter int   ADDR_W    = 32,
    parameter int   REG_W     = 6,
    parameter opc_t OPC_XOR   = 8'h2A,
    parameter opc_t OPC_MACRO = 8'h2B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_insn,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [63:0]       out_insn,
    output logic              out_last,
    output logic              misalign_err,
    output logic              illegal_err
);

    localparam int PAD_W = FIELD_W - REG_W;

    logic             accept;
    logic             take;
    logic             is_macro;
    logic             misaligned;
    logic             bad_range;
    logic [REG_W-1:0] first_reg;
    logic [REG_W-1:0] last_reg;
    logic             start_walk;
    logic             load_plain;
    logic             walk_active;
    logic [REG_W-1:0] walk_idx;
    logic             walk_end;
    logic             slot_valid;
    insn_t            plain_word;

    mx_classify #(
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .ALIGN_LSB (3),
        .OPC_MACRO (OPC_MACRO)
    ) u_classify (
        .insn       (in_insn),
        .addr       (in_addr),
        .is_macro   (is_macro),
        .misaligned (misaligned),
        .bad_range  (bad_range),
        .first_reg  (first_reg),
        .last_reg   (last_reg)
    );

    // Handshakes: input taken only with an empty slot and no flush.
    always_comb begin
        in_ready   = !slot_valid && !flush;
        accept     = in_valid && in_ready;
        take       = slot_valid && out_ready;
        start_walk = accept && !misaligned && is_macro && !bad_range;
        load_plain = accept && !misaligned && !is_macro;
    end

    mx_range_walker #(
        .REG_W (REG_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .start     (start_walk),
        .first_reg (first_reg),
        .last_reg  (last_reg),
        .step      (take && walk_active),
        .active    (walk_active),
        .idx       (walk_idx),
        .at_end    (walk_end)
    );

    // Output slot occupancy: filled by a good word, emptied by the final take or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            slot_valid <= 1'b0;
        end else if (start_walk || load_plain) begin
            slot_valid <= 1'b1;
        end else if (take && (!walk_active || walk_end)) begin
            slot_valid <= 1'b0;
        end
    end

    // Captures a pass-through word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plain_word <= '0;
        end else if (load_plain) begin
            plain_word <= in_insn;
        end
    end

    // Error pulses, set for one cycle after a rejected word is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misalign_err <= 1'b0;
            illegal_err  <= 1'b0;
        end else begin
            misalign_err <= accept && misaligned;
            illegal_err  <= accept && !misaligned && is_macro && bad_range;
        end
    end

    // Output word: either the held plain word or the current self-XOR.
    always_comb begin
        out_valid = slot_valid;
        if (walk_active) begin
            out_insn = make_self_xor(OPC_XOR, {{PAD_W{1'b0}}, walk_idx});
            out_last = walk_end;
        end else begin
            out_insn = plain_word;
            out_last = 1'b1;
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7
    AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_insn))); // R8
    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R9
    AST_MISALIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_err |-> (!out_valid && !illegal_err)); // R3
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_err |-> !out_valid); // R6

endmodule

// File: tb/sim_macro_expander.sv
module sim_macro_expander;

    localparam logic [7:0] OP_X  = 8'h2A;
    localparam logic [7:0] OP_XM = 8'h2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_insn = '0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_insn;
    logic        out_last;
    logic        misalign_err;
    logic        illegal_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit hold   = 0;
    bit mon_on = 0;
    int cyc    = 0;

    logic [63:0] exp_w [0:4095];
    logic        exp_l [0:4095];
    int wr = 0;
    int rd = 0;

    always #2 clk = ~clk;

    macro_expander u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn), .out_last(out_last),
        .misalign_err(misalign_err), .illegal_err(illegal_err)
    );

    function automatic logic [63:0] xr(int i);
        logic [7:0] f;
        f = 8'(i);
        return {OP_X, f, f, f, 32'h0};
    endfunction

    function automatic logic [63:0] xrm(logic [7:0] n, logic [7:0] m);
        return {OP_XM, n, m, 40'h12345};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Downstream monitor: sets readiness, then checks the coming handshake.
    logic [63:0] stall_w;
    bit stalled = 0;
    bit prev_last_take = 0;
    always @(negedge clk) begin
        cyc++;
        out_ready <= !hold && (cyc % 5 != 3) && (cyc % 7 != 0);
        #1;
        if (mon_on) begin
            if (prev_last_take && !flush)
                chk(in_ready == 1'b1, "R7 ready after last", {63'b0, in_ready}, 64'd1);
            if (out_valid)
                chk(in_ready == 1'b0, "R7 busy blocks input", {63'b0, in_ready}, 64'd0);
            if (stalled && !flush)
                chk(out_valid && out_insn == stall_w, "R8 stall hold", out_insn, stall_w);
            stalled = out_valid && !out_ready;
            stall_w = out_insn;
            prev_last_take = out_valid && out_ready && out_last;
            if (out_valid && out_ready) begin
                if (rd >= wr) begin
                    chk(1'b0, "R4 unexpected output", out_insn, 64'd0);
                end else begin
                    chk(out_insn == exp_w[rd], "R4 R2 word", out_insn, exp_w[rd]);
                    chk(out_last == exp_l[rd], "R5 last flag", {63'b0, out_last}, {63'b0, exp_l[rd]});
                    rd++;
                end
            end
        end
    end

    // Sends one word, then checks error pulses and slot fill after acceptance.
    task automatic send(logic [63:0] w, logic [31:0] a, bit e_mis, bit e_ill, bit e_out);
        @(negedge clk);
        in_valid = 1'b1; in_insn = w; in_addr = a;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
        chk(misalign_err == e_mis, "R3 misalign pulse", {63'b0, misalign_err}, {63'b0, e_mis});
        chk(illegal_err == e_ill, "R6 illegal pulse", {63'b0, illegal_err}, {63'b0, e_ill});
        chk(out_valid == e_out, "R2 out_valid after accept", {63'b0, out_valid}, {63'b0, e_out});
        if (e_mis || e_ill) begin
            @(posedge clk); #1;
            chk(!misalign_err && !illegal_err, "R3 R6 pulse one cycle",
                {62'b0, misalign_err, illegal_err}, 64'd0);
        end
    endtask

    task automatic send_macro(int n, int m, logic [31:0] a);
        if (n > m || n > 63 || m > 63) begin
            send(xrm(8'(n), 8'(m)), a, 1'b0, 1'b1, 1'b0);
        end else begin
            for (int i = n; i <= m; i++) begin
                exp_w[wr] = xr(i);
                exp_l[wr] = (i == m);
                wr++;
            end
            send(xrm(8'(n), 8'(m)), a, 1'b0, 1'b0, 1'b1);
        end
    endtask

    task automatic drain();
        int t;
        t = 0;
        while ((rd < wr || out_valid) && t < 2000) begin @(negedge clk); t++; end
        #2;
        chk(rd == wr, "R4 all expected emitted", 64'(rd), 64'(wr));
        wr = 0; rd = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && in_ready && !misalign_err && !illegal_err, "R1 reset state",
            {60'b0, out_valid, in_ready, misalign_err, illegal_err}, 64'b0100);
        mon_on = 1;

        // R4 R5 R6 R10: sweep of small ranges in both orders, diagonal included
        for (int n = 0; n < 16; n++)
            for (int m = 0; m < 16; m++)
                send_macro(n, m, 32'(8 * (n + m)));
        drain();

        // R4 R10: top end of the register file
        send_macro(0, 63, 32'h100);
        send_macro(62, 63, 32'h108);
        send_macro(63, 63, 32'h110);
        drain();

        // R6: padding bits set in either field
        send(xrm(8'h40, 8'h41), 32'h0, 1'b0, 1'b1, 1'b0);
        send(xrm(8'h00, 8'h80), 32'h8, 1'b0, 1'b1, 1'b0);
        send(xrm(8'h85, 8'h05), 32'h10, 1'b0, 1'b1, 1'b0);

        // R2 R5: pass-through words, including a hand-written XOR
        for (int k = 0; k < 24; k++) begin
            logic [63:0] w;
            w = {8'(k * 11 + 1), 56'(64'h9E3779B97F4A7C15 * (k + 1))};
            if (w[63:56] == OP_XM) w[63:56] = 8'hFF;
            exp_w[wr] = w; exp_l[wr] = 1'b1; wr++;
            send(w, 32'(k * 8), 1'b0, 1'b0, 1'b1);
        end
        exp_w[wr] = xr(5); exp_l[wr] = 1'b1; wr++;
        send(xr(5), 32'h40, 1'b0, 1'b0, 1'b1);
        drain();

        // R3: every misaligned low-address pattern, with macros good and bad and plain words
        for (int a = 1; a < 8; a++) begin
            send(xrm(8'd2, 8'd9), 32'(a), 1'b1, 1'b0, 1'b0);
            send(xrm(8'd9, 8'd2), 32'(64 + a), 1'b1, 1'b0, 1'b0);
            send(64'h0102030405060708, 32'(128 + a), 1'b1, 1'b0, 1'b0);
        end
        drain();

        // R9 R8: stall an expansion, flush it together with a pending input
        @(negedge clk);
        hold = 1;
        send(xrm(8'd0, 8'd10), 32'h200, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid && out_insn == xr(0), "R8 frozen index", out_insn, xr(0));
        mon_on = 0;
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_insn = 64'hAAAA_0000_0000_0001; in_addr = 32'h0;
        #1;
        chk(in_ready == 1'b0, "R9 no accept in flush", {63'b0, in_ready}, 64'd0);
        @(posedge clk); #1;
        flush = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R9 output cleared", {63'b0, out_valid}, 64'd0);
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R9 pending input dropped", {63'b0, out_valid}, 64'd0);
        hold = 0;
        wr = 0; rd = 0;
        stalled = 0; prev_last_take = 0;
        @(negedge clk);
        mon_on = 1;
        send_macro(3, 6, 32'h300);
        drain();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule